// File: doc/BRIEF.md
# Call Redirect and Return-Push Unit

This block carries out the control-transfer part of a procedure call in flat or real-address operation. It accepts one call at a time, together with the call form, the operand-size attribute, the address of the byte after the call instruction, the current code segment, the displacement or fetched target, and the current stack pointer. It works out the destination offset and segment. It then issues the return-address stores as a stream of push requests, each carrying its value, its width and its already-decremented stack address.

Fetching indirect operands, descriptor checks and paging are done elsewhere; any fetched target offset and selector arrive on input ports. The new instruction pointer, code segment and stack pointer change together with a one-cycle completion pulse. In real-address operation a call whose stack stores or destination offset would leave the 16-bit offset range does not issue any stores, and completes with a fault flag instead.

Top module: `call_redirect`

## Requirements
- R1: For a near relative call (form 0), the new EIP is nextEip plus the displacement. At operand size 32 the full 32-bit disp is added. At size 16, disp[15:0] is sign-extended and the sum is masked to its low 16 bits.
- R2: For near indirect (form 1), far direct (form 2) and far indirect (form 3), the new EIP is tgtOff at size 32, or tgtOff[15:0] zero-extended at size 16. The upper 16 bits of a size-16 result are always zero.
- R3: A near call (forms 0 and 1) issues exactly one push, which holds the return offset: nextEip at size 32, or nextEip[15:0] zero-extended at size 16. The new CS equals curCs.
- R4: A far call (forms 2 and 3) issues two pushes: curCs zero-extended first, then the return offset as in R3. The new CS equals tgtSel.
- R5: Every push is 4 bytes wide at size 32 (pushWide=1) and 2 bytes wide at size 16 (pushWide=0). Its pushAddr is the running stack pointer minus that width, starting from espIn. The new ESP is espIn minus the total bytes pushed. In flat mode the address arithmetic wraps modulo 2^32 without a fault.
- R6: While pushValid is high and pushReady is low, the request stays valid and pushData and pushAddr stay unchanged. A push is taken in each cycle where both signals are high.
- R7: done is high for exactly one cycle, in the cycle after the last accepted push. newEip, newCs and newEsp change in that same cycle and at no other time.
- R8: When realMode=1, the call faults if espIn > FFFFh, if espIn is less than the total bytes to push, or if the new EIP would exceed FFFFh. A faulting call issues no push. It raises done and fault in the cycle after start, and leaves newEip, newCs and newEsp unchanged.
- R9: After reset, pushValid, done, fault and busy are 0, and newEip, newCs and newEsp are 0.
- R10: A start pulse while busy is high is ignored, and the call in progress completes with its own values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a call (sampled while idle) |
| form | input | 2 | 0 near relative, 1 near indirect, 2 far direct, 3 far indirect |
| opSize32 | input | 1 | Operand size: 1 = 32 bits, 0 = 16 bits |
| realMode | input | 1 | 1 = real-address range checks enabled, 0 = flat |
| nextEip | input | 32 | Address of the byte after the call instruction |
| curCs | input | 16 | Current code segment |
| disp | input | 32 | Relative displacement |
| tgtOff | input | 32 | Fetched or immediate target offset |
| tgtSel | input | 16 | Target segment for far calls |
| espIn | input | 32 | Stack pointer at the start of the call |
| pushReady | input | 1 | Stack store accepts the current push |
| pushValid | output | 1 | Push request present |
| pushData | output | 32 | Value to store (zero-extended when narrow) |
| pushAddr | output | 32 | Decremented stack address for this push |
| pushWide | output | 1 | 1 = 4-byte push, 0 = 2-byte push |
| newEip | output | 32 | Instruction pointer after the call |
| newCs | output | 16 | Code segment after the call |
| newEsp | output | 32 | Stack pointer after the call |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Completion was a real-mode range fault |
| busy | output | 1 | A call is in progress |

## Verification
A corrupted captured stack pointer shows up at the first push as a wrong pushAddr, and again at completion as a wrong newEsp. A sequencer that skips or repeats a state shows up in the same call as a push count that does not match the form, or as done arriving out of step with the last accepted push. A wrong push value or segment select shows up in the pushData of that cycle. Target arithmetic errors, such as a missing mask or wrong sign extension, appear only in newEip in the done cycle. The stimulus therefore includes displacements and offsets that straddle the 16-bit boundary, as well as calls run with a throttled pushReady.

// File: rtl/call_redirect_pkg.sv
package call_redirect_pkg;

  typedef enum logic [1:0] {
    FORM_NEAR_REL = 2'd0,
    FORM_NEAR_IND = 2'd1,
    FORM_FAR_DIR  = 2'd2,
    FORM_FAR_IND  = 2'd3
  } callForm_t;

  // strobes from sequencer to datapath
  typedef struct packed {
    logic load;     // capture operands at start
    logic pushSeg;  // current push carries the segment
    logic step;     // a push is accepted this cycle
    logic commit;   // last push accepted: update architectural outputs
  } dpStrobe_t;

endpackage

// File: rtl/call_redirect_dp.sv
module call_redirect_dp
  import call_redirect_pkg::*;
#(
  parameter int OFF_W = 32,
  parameter int SEL_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strb,
  input  logic [1:0]       form,
  input  logic             opSize32,
  input  logic             realMode,
  input  logic [OFF_W-1:0] nextEip,
  input  logic [SEL_W-1:0] curCs,
  input  logic [OFF_W-1:0] disp,
  input  logic [OFF_W-1:0] tgtOff,
  input  logic [SEL_W-1:0] tgtSel,
  input  logic [OFF_W-1:0] espIn,
  output logic             faultDet,
  output logic             isFar,
  output logic [OFF_W-1:0] pushData,
  output logic [OFF_W-1:0] pushAddr,
  output logic             pushWide,
  output logic [OFF_W-1:0] newEip,
  output logic [SEL_W-1:0] newCs,
  output logic [OFF_W-1:0] newEsp
);

  localparam int HALF_W = OFF_W / 2;
  localparam logic [OFF_W-1:0] REAL_LIMIT = {{(OFF_W-HALF_W){1'b0}}, {HALF_W{1'b1}}};
  localparam logic [OFF_W-1:0] WIDE_BYTES = OFF_W'(4);
  localparam logic [OFF_W-1:0] NARROW_BYTES = OFF_W'(2);

  logic [OFF_W-1:0] dispExt, relSum, rawTgt, tgtCalc, totalBytes, retCalc;
  logic [OFF_W-1:0] tgtEipQ, retQ, segQ, espQ, stepBytes;
  logic [SEL_W-1:0] tgtCsQ;
  logic             wideQ;

  // target offset
  always_comb begin
    dispExt = opSize32 ? disp : {{(OFF_W-HALF_W){disp[HALF_W-1]}}, disp[HALF_W-1:0]};
    relSum  = nextEip + dispExt;
    rawTgt  = (callForm_t'(form) == FORM_NEAR_REL) ? relSum : tgtOff;
    tgtCalc = opSize32 ? rawTgt : {{(OFF_W-HALF_W){1'b0}}, rawTgt[HALF_W-1:0]};
    retCalc = opSize32 ? nextEip : {{(OFF_W-HALF_W){1'b0}}, nextEip[HALF_W-1:0]};
  end

  // real-mode range check
  always_comb begin
    isFar = form[1];
    if (isFar) totalBytes = opSize32 ? (WIDE_BYTES << 1) : (NARROW_BYTES << 1);
    else       totalBytes = opSize32 ? WIDE_BYTES : NARROW_BYTES;
    faultDet = realMode && ((espIn > REAL_LIMIT) || (espIn < totalBytes) ||
                            (tgtCalc > REAL_LIMIT));
  end

  assign stepBytes = wideQ ? WIDE_BYTES : NARROW_BYTES;
  assign pushAddr  = espQ - stepBytes;
  assign pushData  = strb.pushSeg ? segQ : retQ;
  assign pushWide  = wideQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tgtEipQ <= '0;
      tgtCsQ  <= '0;
      retQ    <= '0;
      segQ    <= '0;
      espQ    <= '0;
      wideQ   <= 1'b0;
    end else if (strb.load) begin
      tgtEipQ <= tgtCalc;
      tgtCsQ  <= isFar ? tgtSel : curCs;
      retQ    <= retCalc;
      segQ    <= {{(OFF_W-SEL_W){1'b0}}, curCs};
      espQ    <= espIn;
      wideQ   <= opSize32;
    end else if (strb.step) begin
      espQ    <= pushAddr;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      newEip <= '0;
      newCs  <= '0;
      newEsp <= '0;
    end else if (strb.commit) begin
      newEip <= tgtEipQ;
      newCs  <= tgtCsQ;
      newEsp <= pushAddr;
    end
  end

  // R2: a 16-bit call never leaves upper EIP bits set
  assert_eip_upper_clear_R2: assert property (@(posedge clk) disable iff (!rstN)
    (strb.commit && !wideQ) |=> (newEip[OFF_W-1:HALF_W] == '0));

  // R5: consecutive pushes move down by the push width
  assert_push_addr_step_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.step && !strb.commit) |=> (pushAddr == $past(pushAddr) - stepBytes));

endmodule

// File: rtl/call_redirect_ctrl.sv
module call_redirect_ctrl
  import call_redirect_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       faultDet,
  input  logic       isFar,
  input  logic       pushReady,
  output dpStrobe_t  strb,
  output logic       pushValid,
  output logic       done,
  output logic       fault,
  output logic       busy
);

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEG  = 2'd1,
    ST_RET  = 2'd2,
    ST_FIN  = 2'd3
  } seqState_t;

  seqState_t state, stateNext;
  logic      faultQ;

  always_comb begin
    strb.load    = (state == ST_IDLE) && start;
    strb.pushSeg = (state == ST_SEG);
    pushValid    = (state == ST_SEG) || (state == ST_RET);
    strb.step    = pushValid && pushReady;
    strb.commit  = (state == ST_RET) && pushReady;
    done         = (state == ST_FIN);
    fault        = done && faultQ;
    busy         = (state != ST_IDLE);
  end

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE: if (start) stateNext = faultDet ? ST_FIN : (isFar ? ST_SEG : ST_RET);
      ST_SEG:  if (pushReady) stateNext = ST_RET;
      ST_RET:  if (pushReady) stateNext = ST_FIN;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      faultQ <= 1'b0;
    end else begin
      state <= stateNext;
      if (strb.load) faultQ <= faultDet;
    end
  end

  // R7: completion is a single-cycle pulse
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R6: an unaccepted push stays offered
  assert_push_held_R6: assert property (@(posedge clk) disable iff (!rstN)
    (pushValid && !pushReady) |=> pushValid);

  // R8: a faulting call completes next cycle without pushing
  assert_fault_no_push_R8: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && start && faultDet) |=> (fault && !pushValid));

endmodule

// File: rtl/call_redirect.sv
module call_redirect
  import call_redirect_pkg::*;
#(
  parameter int OFF_W = 32,
  parameter int SEL_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [1:0]       form,
  input  logic             opSize32,
  input  logic             realMode,
  input  logic [OFF_W-1:0] nextEip,
  input  logic [SEL_W-1:0] curCs,
  input  logic [OFF_W-1:0] disp,
  input  logic [OFF_W-1:0] tgtOff,
  input  logic [SEL_W-1:0] tgtSel,
  input  logic [OFF_W-1:0] espIn,
  input  logic             pushReady,
  output logic             pushValid,
  output logic [OFF_W-1:0] pushData,
  output logic [OFF_W-1:0] pushAddr,
  output logic             pushWide,
  output logic [OFF_W-1:0] newEip,
  output logic [SEL_W-1:0] newCs,
  output logic [OFF_W-1:0] newEsp,
  output logic             done,
  output logic             fault,
  output logic             busy
);

  dpStrobe_t strb;
  logic      faultDet, isFar;

  call_redirect_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .faultDet  (faultDet),
    .isFar     (isFar),
    .pushReady (pushReady),
    .strb      (strb),
    .pushValid (pushValid),
    .done      (done),
    .fault     (fault),
    .busy      (busy)
  );

  call_redirect_dp #(.OFF_W(OFF_W), .SEL_W(SEL_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .form     (form),
    .opSize32 (opSize32),
    .realMode (realMode),
    .nextEip  (nextEip),
    .curCs    (curCs),
    .disp     (disp),
    .tgtOff   (tgtOff),
    .tgtSel   (tgtSel),
    .espIn    (espIn),
    .faultDet (faultDet),
    .isFar    (isFar),
    .pushData (pushData),
    .pushAddr (pushAddr),
    .pushWide (pushWide),
    .newEip   (newEip),
    .newCs    (newCs),
    .newEsp   (newEsp)
  );

  // R6: a stalled push keeps its value and address
  assert_push_stable_R6: assert property (@(posedge clk) disable iff (!rstN)
    (pushValid && !pushReady) |=> ($stable(pushData) && $stable(pushAddr)));

  // R7: architectural outputs move only with the completion pulse
  assert_outputs_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(done) && !done) |-> ($stable(newEip) && $stable(newEsp)) or done);

  // R10: a second start while busy does not reload the width
  assert_busy_ignores_start_R10: assert property (@(posedge clk) disable iff (!rstN)
    (busy && pushValid && start && !pushReady) |=> $stable(pushWide));

endmodule

// File: tb/call_redirect_test.sv
module call_redirect_test;

  localparam time CLK_PERIOD = 10ns;

  typedef struct packed {
    logic [1:0]  form;
    logic        sz32;
    logic        isReal;
    logic [31:0] nextEip;
    logic [15:0] cs;
    logic [31:0] disp;
    logic [31:0] tgtOff;
    logic [15:0] sel;
    logic [31:0] esp;
    logic [31:0] expEip;
    logic [15:0] expCs;
    logic [31:0] expEsp;
    logic        expFault;
  } vec_t;

  localparam int NVEC = 13;
  localparam vec_t VECS [NVEC] = '{
    // R1 near relative, size 32, negative displacement
    '{2'd0, 1'b1, 1'b0, 32'h00401005, 16'h0008, 32'hFFFFFFF0, 32'h0, 16'h0, 32'h00100000,
      32'h00400FF5, 16'h0008, 32'h000FFFFC, 1'b0},
    // R1 size 16, sum carries past 16 bits and is masked
    '{2'd0, 1'b0, 1'b1, 32'h0000FFF0, 16'h1234, 32'h00000020, 32'h0, 16'h0, 32'h00000200,
      32'h00000010, 16'h1234, 32'h000001FE, 1'b0},
    // R1 size 16, disp low half 8000h sign-extends, upper disp ignored
    '{2'd0, 1'b0, 1'b1, 32'h00001000, 16'h2000, 32'h12348000, 32'h0, 16'h0, 32'h00001000,
      32'h00009000, 16'h2000, 32'h00000FFE, 1'b0},
    // R2 near indirect size 32
    '{2'd1, 1'b1, 1'b0, 32'h12345678, 16'h0010, 32'h0, 32'hDEADBEEF, 16'h0, 32'h80000000,
      32'hDEADBEEF, 16'h0010, 32'h7FFFFFFC, 1'b0},
    // R2 near indirect size 16 zero-extends
    '{2'd1, 1'b0, 1'b1, 32'h00000ABC, 16'h0F00, 32'h0, 32'hABCD1234, 16'h0, 32'h0000FFFE,
      32'h00001234, 16'h0F00, 32'h0000FFFC, 1'b0},
    // R4 far direct size 16
    '{2'd2, 1'b0, 1'b1, 32'h00000100, 16'h1000, 32'h0, 32'h00015678, 16'hF000, 32'h00000100,
      32'h00005678, 16'hF000, 32'h000000FC, 1'b0},
    // R4 far indirect size 32 flat
    '{2'd3, 1'b1, 1'b0, 32'h00200010, 16'h0018, 32'h0, 32'h00C0FFEE, 16'h0028, 32'h00010008,
      32'h00C0FFEE, 16'h0028, 32'h00010000, 1'b0},
    // R8 boundary: exactly 8 bytes of real-mode stack
    '{2'd2, 1'b1, 1'b1, 32'h00000777, 16'h0030, 32'h0, 32'h0000ABCD, 16'h0040, 32'h00000008,
      32'h0000ABCD, 16'h0040, 32'h00000000, 1'b0},
    // R8 fault: stack too small for far size 16
    '{2'd2, 1'b0, 1'b1, 32'h00000123, 16'h0999, 32'h0, 32'h00001111, 16'h0888, 32'h00000003,
      32'h0000ABCD, 16'h0040, 32'h00000000, 1'b1},
    // R8 fault: stack pointer beyond FFFFh
    '{2'd0, 1'b1, 1'b1, 32'h00000050, 16'h0777, 32'h00000004, 32'h0, 16'h0, 32'h00010000,
      32'h0000ABCD, 16'h0040, 32'h00000000, 1'b1},
    // R8 fault: target offset beyond FFFFh
    '{2'd1, 1'b1, 1'b1, 32'h00000050, 16'h0777, 32'h0, 32'h00010000, 16'h0, 32'h00000100,
      32'h0000ABCD, 16'h0040, 32'h00000000, 1'b1},
    // R5 flat mode wraps the stack address without fault
    '{2'd0, 1'b1, 1'b0, 32'h00000010, 16'h0008, 32'h00000020, 32'h0, 16'h0, 32'h00000002,
      32'h00000030, 16'h0008, 32'hFFFFFFFE, 1'b0},
    // R8 boundary: 2 bytes of real-mode stack, disp -1
    '{2'd0, 1'b0, 1'b1, 32'h00000050, 16'h0700, 32'h0000FFFF, 32'h0, 16'h0, 32'h00000002,
      32'h0000004F, 16'h0700, 32'h00000000, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  form = '0;
  logic        opSize32 = 1'b0;
  logic        realMode = 1'b0;
  logic [31:0] nextEip = '0;
  logic [15:0] curCs = '0;
  logic [31:0] disp = '0;
  logic [31:0] tgtOff = '0;
  logic [15:0] tgtSel = '0;
  logic [31:0] espIn = '0;
  logic        pushReady = 1'b1;
  logic        pushValid, pushWide, done, fault, busy;
  logic [31:0] pushData, pushAddr, newEip, newEsp;
  logic [15:0] newCs;

  int checks = 0;
  int errors = 0;

  logic [31:0] gotData [4];
  logic [31:0] gotAddr [4];
  logic        gotWide [4];
  int          nPush, lastPush, doneCyc;

  always #(CLK_PERIOD/2) clk = ~clk;

  call_redirect uut (
    .clk(clk), .rstN(rstN), .start(start), .form(form), .opSize32(opSize32),
    .realMode(realMode), .nextEip(nextEip), .curCs(curCs), .disp(disp),
    .tgtOff(tgtOff), .tgtSel(tgtSel), .espIn(espIn), .pushReady(pushReady),
    .pushValid(pushValid), .pushData(pushData), .pushAddr(pushAddr),
    .pushWide(pushWide), .newEip(newEip), .newCs(newCs), .newEsp(newEsp),
    .done(done), .fault(fault), .busy(busy)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // runs after start was applied; collects pushes until done
  task automatic collect(input bit stall);
    logic [31:0] holdEip, holdEsp, prevData, prevAddr;
    bit prevStall;
    holdEip = newEip;
    holdEsp = newEsp;
    prevStall = 1'b0;
    prevData = '0;
    prevAddr = '0;
    nPush = 0;
    lastPush = -10;
    doneCyc = -1;
    for (int c = 0; c < 40; c++) begin
      pushReady = stall ? c[0] : 1'b1;
      #1;
      if (prevStall)
        chk(pushValid && pushData == prevData && pushAddr == prevAddr,
            "R6 stalled push held", pushData, prevData);
      if (done) begin
        doneCyc = c;
        break;
      end
      chk(newEip == holdEip && newEsp == holdEsp, "R7 outputs hold before done",
          newEip, holdEip);
      prevStall = pushValid && !pushReady;
      prevData = pushData;
      prevAddr = pushAddr;
      if (pushValid && pushReady && nPush < 4) begin
        gotData[nPush] = pushData;
        gotAddr[nPush] = pushAddr;
        gotWide[nPush] = pushWide;
        nPush++;
        lastPush = c;
      end
      @(negedge clk);
    end
    pushReady = 1'b1;
  endtask

  task automatic runVec(input vec_t v, input bit stall);
    logic [31:0] w, ret, first;
    int expN;
    @(negedge clk);
    form = v.form; opSize32 = v.sz32; realMode = v.isReal; nextEip = v.nextEip;
    curCs = v.cs; disp = v.disp; tgtOff = v.tgtOff; tgtSel = v.sel; espIn = v.esp;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    collect(stall);
    w = v.sz32 ? 32'd4 : 32'd2;
    ret = v.sz32 ? v.nextEip : {16'h0, v.nextEip[15:0]};
    expN = v.expFault ? 0 : (v.form[1] ? 2 : 1);
    chk(doneCyc >= 0, "R7 done seen", 32'(doneCyc), 32'd0);
    chk(fault == v.expFault, "R8 fault flag", {31'h0, fault}, {31'h0, v.expFault});
    chk(nPush == expN, "R3 R4 push count", 32'(nPush), 32'(expN));
    if (v.expFault)
      chk(doneCyc == 0, "R8 fault completes next cycle", 32'(doneCyc), 32'd0);
    else
      chk(doneCyc == lastPush + 1, "R7 done after last push", 32'(doneCyc),
          32'(lastPush + 1));
    if (nPush == expN && expN > 0) begin
      first = v.form[1] ? {16'h0, v.cs} : ret;
      chk(gotData[0] == first, "R3 R4 first push value", gotData[0], first);
      chk(gotAddr[0] == v.esp - w, "R5 first push address", gotAddr[0], v.esp - w);
      chk(gotWide[0] == v.sz32, "R5 push width", {31'h0, gotWide[0]}, {31'h0, v.sz32});
      if (expN == 2) begin
        chk(gotData[1] == ret, "R4 return offset second", gotData[1], ret);
        chk(gotAddr[1] == v.esp - 2*w, "R5 second push address", gotAddr[1], v.esp - 2*w);
      end
    end
    chk(newEip == v.expEip, "R1 R2 new EIP", newEip, v.expEip);
    chk(newCs == v.expCs, "R3 R4 new CS", {16'h0, newCs}, {16'h0, v.expCs});
    chk(newEsp == v.expEsp, "R5 new ESP", newEsp, v.expEsp);
    @(negedge clk);
    #1;
    chk(!done && !busy, "R7 done lasts one cycle", {31'h0, done}, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    #1;
    // R9 reset state
    chk(!pushValid && !done && !fault && !busy, "R9 reset control outputs",
        {28'h0, pushValid, done, fault, busy}, 32'h0);
    chk(newEip == '0 && newEsp == '0 && newCs == '0, "R9 reset architectural outputs",
        newEip, 32'h0);

    for (int i = 0; i < NVEC; i++) runVec(VECS[i], i[0]);

    // R10: restart while busy is ignored
    @(negedge clk);
    form = 2'd2; opSize32 = 1'b0; realMode = 1'b0; nextEip = 32'h00002222;
    curCs = 16'h3333; disp = '0; tgtOff = 32'h00004444; tgtSel = 16'h5555;
    espIn = 32'h00006000; pushReady = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (2) @(negedge clk);
    form = 2'd0; opSize32 = 1'b1; nextEip = 32'h0000AAAA; curCs = 16'h0001;
    espIn = 32'h00000100; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    collect(1'b0);
    chk(nPush == 2, "R10 push count unchanged", 32'(nPush), 32'd2);
    if (nPush == 2) begin
      chk(gotData[0] == 32'h00003333 && gotAddr[0] == 32'h00005FFE,
          "R10 first push from first call", gotData[0], 32'h00003333);
      chk(gotData[1] == 32'h00002222 && gotAddr[1] == 32'h00005FFC,
          "R10 second push from first call", gotData[1], 32'h00002222);
    end
    chk(newEip == 32'h00004444 && newCs == 16'h5555 && newEsp == 32'h00005FFC,
        "R10 outputs from first call", newEip, 32'h00004444);
    @(negedge clk);
    #1;
    chk(!busy && !pushValid, "R10 idle after call", {30'h0, busy, pushValid}, 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule